// File: doc/BRIEF.md
# Six-State Irregular Sequence Counter

A synchronous 3-bit state machine. On every rising clock edge it moves to the next code of a fixed six-step cycle, 0, 5, 4, 6, 1, 7, and then returns to 0. It has no enable, no load and no direction input. The only controls are the clock and a synchronous active-high reset, which restarts the cycle at 0.

Each register bit is a JK-style storage cell. Per-bit J and K terms come from the present state, and they choose between hold, clear, set and toggle. A separate combinational next-state table is built next to the JK path, and the checker compares the two on every cycle.

The codes 2 and 3 are not part of the cycle. They were don't-cares when the excitation equations were derived. The chosen equations still send both of them to 0 on the next edge, so the counter cannot get stuck outside its cycle.

Top module: `seqc_counter`

## Requirements
- R1: After reset is released, each rising clock edge moves `count` one step along the order 0 → 5 → 4 → 6 → 1 → 7.
- R2: From code 7 the next rising edge gives code 0, and the cycle then repeats without end. Twelve edges from reset show the six codes exactly twice.
- R3: When `rst` is high at a rising edge, `count` is 0 after that edge. This holds whatever the count was.
- R4: Each state bit follows the JK rule on the rising edge, with (J,K) = (0,0) hold, (0,1) clear to 0, (1,0) set to 1, (1,1) invert.
- R5: In normal operation after reset, `count` never shows code 2 or code 3.
- R6: The excitation logic sends both unused codes, 2 (binary 010) and 3 (binary 011), to code 0 on the next edge.
- R7: For all eight 3-bit codes, the JK excitation path and the combinational next-state table give the same next code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; forces code 0 |
| count | output | 3 | Present code of the six-step cycle |

## Verification
A wrong J or K term on one bit shows up at `count` on the very next rising edge, as a code that breaks the order. From then on every later step is off too, because the next state depends only on the present code. A fault that touches only code 2 or 3 cannot reach the ports in normal running. For that reason the excitation stage is also driven directly with every code, including the two unused ones, and its outputs are compared against an independent model.

// File: rtl/seqc_pkg.sv
package seqc_pkg;
  localparam int unsigned SEQ_W = 3;
  typedef logic [SEQ_W-1:0] seq_code_t;

  // Apply the JK update rule bit by bit.
  function automatic seq_code_t jk_step(input seq_code_t q,
                                        input seq_code_t j,
                                        input seq_code_t k);
    seq_code_t r;
    for (int b = 0; b < SEQ_W; b++) begin
      case ({j[b], k[b]})
        2'b00:   r[b] = q[b];
        2'b01:   r[b] = 1'b0;
        2'b10:   r[b] = 1'b1;
        default: r[b] = ~q[b];
      endcase
    end
    return r;
  endfunction

  // Successor of each code; unused codes return to the start.
  function automatic seq_code_t seq_succ(input seq_code_t q);
    case (q)
      3'd0:    return 3'd5;
      3'd5:    return 3'd4;
      3'd4:    return 3'd6;
      3'd6:    return 3'd1;
      3'd1:    return 3'd7;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/seqc_jk_excite.sv
module seqc_jk_excite
  import seqc_pkg::*;
(
  input  logic [SEQ_W-1:0] state,
  output logic [SEQ_W-1:0] j_term,
  output logic [SEQ_W-1:0] k_term
);
  logic q2, q1, q0;
  assign {q2, q1, q0} = state;

  // Minimised equations, with the unused codes chosen so that they reach 0.
  assign j_term[2] = ~q1;
  assign k_term[2] =  q1;
  assign j_term[1] =  q2 ^ q0;
  assign k_term[1] =  1'b1;
  assign j_term[0] = ~(q2 ^ q1);
  assign k_term[0] =  q2 | q1;
endmodule

// File: rtl/seqc_table.sv
module seqc_table
  import seqc_pkg::*;
(
  input  logic [SEQ_W-1:0] state,
  output logic [SEQ_W-1:0] nxt
);
  always_comb nxt = seq_succ(state);
endmodule

// File: rtl/seqc_jk_reg.sv
module seqc_jk_reg #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] j,
  input  logic [W-1:0] k,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) begin
        q[b] <= 1'b0;
      end else begin
        case ({j[b], k[b]})
          2'b00:   q[b] <= q[b];
          2'b01:   q[b] <= 1'b0;
          2'b10:   q[b] <= 1'b1;
          default: q[b] <= ~q[b];
        endcase
      end
    end
  end
endmodule

// File: rtl/seqc_counter.sv
module seqc_counter
  import seqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  output logic [SEQ_W-1:0] count
);
  logic [SEQ_W-1:0] j_term, k_term;
  logic [SEQ_W-1:0] nxt_jk;   // successor implied by the JK terms
  logic [SEQ_W-1:0] nxt_tab;  // successor from the plain table

  seqc_jk_excite u_exc (
    .state  (count),
    .j_term (j_term),
    .k_term (k_term)
  );

  seqc_table u_tab (
    .state (count),
    .nxt   (nxt_tab)
  );

  assign nxt_jk = jk_step(count, j_term, k_term);

  seqc_jk_reg #(.W(SEQ_W)) u_reg (
    .clk (clk),
    .rst (rst),
    .j   (j_term),
    .k   (k_term),
    .q   (count)
  );
endmodule

// File: rtl/seqc_counter_chk.sv
module seqc_counter_chk
  import seqc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [SEQ_W-1:0] count,
  input logic [SEQ_W-1:0] nxt_jk,
  input logic [SEQ_W-1:0] nxt_tab
);
  // R1
  a_r1_order: assert property (@(posedge clk) disable iff (rst)
    (count == 3'd0 || count == 3'd5 || count == 3'd4 || count == 3'd6 || count == 3'd1)
      |=> count == seq_succ($past(count)));
  // R2
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    count == 3'd7 |=> count == 3'd0);
  // R3
  a_r3_reset_zero: assert property (@(posedge clk)
    rst |=> count == 3'd0);
  // R5
  a_r5_no_unused: assert property (@(posedge clk) disable iff (rst)
    (count != 3'd2) && (count != 3'd3));
  // R7
  a_r7_paths_agree: assert property (@(posedge clk) disable iff (rst)
    nxt_jk == nxt_tab);
endmodule

bind seqc_counter seqc_counter_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .count   (count),
  .nxt_jk  (nxt_jk),
  .nxt_tab (nxt_tab)
);

// File: tb/sim_seqc_counter.sv
module sim_seqc_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] count;

  logic [2:0] ex_state;
  logic [2:0] ex_j, ex_k;
  logic       r_rst = 1'b1;
  logic [0:0] r_j = 1'b0, r_k = 1'b0, r_q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  seqc_counter u0 (.clk(clk), .rst(rst), .count(count));
  seqc_jk_excite u_ex (.state(ex_state), .j_term(ex_j), .k_term(ex_k));
  seqc_jk_reg #(.W(1)) u_cell (.clk(clk), .rst(r_rst), .j(r_j), .k(r_k), .q(r_q));

  // Independent model of the cycle order.
  function automatic logic [2:0] model_next(input logic [2:0] s);
    logic [2:0] order [6] = '{3'd0, 3'd5, 3'd4, 3'd6, 3'd1, 3'd7};
    for (int i = 0; i < 6; i++)
      if (order[i] == s) return order[(i + 1) % 6];
    return 3'd0;
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops one expectation per edge.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) check(tag_q.pop_front(), count, exp_q.pop_front());
  end

  task automatic push(input logic [2:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  initial begin
    logic [2:0] st;
    // R3: reset state
    @(negedge clk); rst = 1'b1; push(3'd0, "R3");
    @(negedge clk); push(3'd0, "R3");
    @(negedge clk);
    // R1/R2: twelve edges, the cycle twice
    rst = 1'b0; st = 3'd0;
    for (int i = 0; i < 12; i++) begin
      st = model_next(st);
      push(st, (st == 3'd0) ? "R2" : "R1");
      @(negedge clk);
    end
    // Run three steps, then R3: reset in mid-cycle
    for (int i = 0; i < 3; i++) begin
      st = model_next(st); push(st, "R1"); @(negedge clk);
    end
    rst = 1'b1; push(3'd0, "R3"); @(negedge clk);
    rst = 1'b0; st = 3'd0;
    for (int i = 0; i < 6; i++) begin
      st = model_next(st); push(st, (st == 3'd0) ? "R2" : "R1"); @(negedge clk);
    end
    @(negedge clk);

    // R6/R7: excitation stage for every code, JK rule applied by the bench
    for (int c = 0; c < 8; c++) begin
      logic [2:0] got;
      ex_state = 3'(c);
      #1;
      for (int b = 0; b < 3; b++)
        got[b] = ex_j[b] & ~ex_k[b] | (ex_j[b] & ex_k[b] & ~ex_state[b]) | (~ex_j[b] & ~ex_k[b] & ex_state[b]);
      if (c == 2 || c == 3) check("R6", got, 3'd0);
      else check("R7", got, model_next(3'(c)));
    end

    // R4: one JK cell, set / hold / toggle / toggle / clear
    @(negedge clk); r_rst = 1'b0; r_j = 1'b1; r_k = 1'b0;
    @(negedge clk); check("R4", {2'b0, r_q}, 3'd1);
    r_j = 1'b0; r_k = 1'b0;
    @(negedge clk); check("R4", {2'b0, r_q}, 3'd1);
    r_j = 1'b1; r_k = 1'b1;
    @(negedge clk); check("R4", {2'b0, r_q}, 3'd0);
    @(negedge clk); check("R4", {2'b0, r_q}, 3'd1);
    r_j = 1'b0; r_k = 1'b1;
    @(negedge clk); check("R4", {2'b0, r_q}, 3'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // R5: unused codes never seen at the port while running
  always @(negedge clk) begin
    if (!rst && (count == 3'd2 || count == 3'd3)) begin
      checks++; errors++;
      $display("FAIL R5: actual=%0d expected=not 2 or 3", count);
    end
  end

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule